// File: doc/BRIEF.md
# Serial Pin Expander Master

This block gives a controller many remote pins through two external shift-register chains. Inputs come from a parallel-in/serial-out chain and outputs go to a serial-in/parallel-out chain. Each scan pulses a load strobe so the input chain captures its pins. The block then clocks one bit per pin in each direction and ends with a latch strobe that updates the external output pins. The shift clock runs from the system clock through a programmable divider, and a scan starts only while the run bit is set.

Every pin has an output bit, a captured input bit and its own interrupt setup. The interrupt setup is an enable bit, a mode bit (level or edge) and a polarity bit. Status bits are sticky, are cleared by writing 1, and feed one interrupt line. A watchdog-reset input clears the output image except for pins whose retain bit is set. The power-on reset clears everything. Registers are 32 bits wide. Each bank of 32 pins has its own set of registers, and the pin count is a parameter that must be a multiple of 8.

Top module: `serial_pin_master`

## Requirements
- R1: After the power-on reset `rst`, every register reads 0, `ser_clk`, `ser_load` and `ser_latch` are low, and `irq` is low.
- R2: Every serial phase lasts divisor+1 system clocks, so each high pulse of `ser_clk` is divisor+1 clocks wide.
- R3: A scan is one `ser_load` pulse, then exactly NPINS rising edges of `ser_clk`, then one `ser_latch` pulse. At most one of `ser_load`, `ser_clk` and `ser_latch` is high in any cycle.
- R4: Bit k sent on `ser_dout` (k from 0) is output pin NPINS-1-k of the output image as it stood when the scan's load phase ended. `ser_dout` does not change on a rising `ser_clk` edge or while `ser_clk` is high.
- R5: `ser_din` is sampled just before each rising `ser_clk` edge, and bit k sampled is input pin k. The input value register takes the whole captured image when the scan ends.
- R6: With mode bit 0 (level), a pin sets its status at the end of every scan in which its captured input equals its polarity bit (1 means high, 0 means low).
- R7: With mode bit 1 (edge), a pin sets its status when its captured input goes from 0 to 1 (polarity 1) or from 1 to 0 (polarity 0) against the previous scan. Before the first scan after reset the previous value counts as 0.
- R8: Status bits change only at the end of a scan or when written. Writing 1 clears a status bit, and writing 0 leaves it unchanged.
- R9: `irq` is high exactly when some pin has both its status bit and its enable bit set. Status is recorded for disabled pins too.
- R10: A one-cycle pulse on `wdt_rst` clears every output-image bit whose retain bit is 0, keeps those whose retain bit is 1, and leaves every other register unchanged.
- R11: Clearing the run bit during a scan lets that scan finish, and no further scan starts.
- R12: `reg_addr[2:0]` selects the register and the upper bits select the bank: 0 output image, 1 input value (read-only), 2 interrupt enable, 3 mode, 4 polarity, 5 status, 6 retain, 7 control (bit 0 run, bits DIV_W:1 divisor, any bank). Writes to a bank index beyond the last bank, and writes to the input value register, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| wdt_rst | input | 1 | Watchdog reset pulse, clears non-retained outputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address {bank, select} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| ser_clk | output | 1 | Shift clock to both chains |
| ser_load | output | 1 | Capture strobe for the input chain |
| ser_latch | output | 1 | Update strobe for the output chain |
| ser_dout | output | 1 | Serial data to the output chain |
| ser_din | input | 1 | Serial data from the input chain |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check the strobe rules, the count of shift edges per scan, the stability of the serial output around the shift clock, the rule that status bits rise only at the end of a scan, and the outcome of a watchdog pulse. The bench carries a model of both external chains. Only this model can show the bit order in each direction, the divider width, the level and edge interrupt results across a series of scans, the write-1-clear behaviour, and the way the run bit stops scanning.

// File: rtl/spm_pkg.sv
package spm_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_LOAD  = 3'd1,
        PH_LOW   = 3'd2,
        PH_HIGH  = 3'd3,
        PH_LATCH = 3'd4
    } phase_e;

    typedef enum logic [2:0] {
        SEL_OUT   = 3'd0,
        SEL_IN    = 3'd1,
        SEL_IEN   = 3'd2,
        SEL_MODE  = 3'd3,
        SEL_POL   = 3'd4,
        SEL_STAT  = 3'd5,
        SEL_KEEP  = 3'd6,
        SEL_CTRL  = 3'd7
    } regsel_e;

    typedef struct packed {
        logic load;
        logic sclk;
        logic latch;
        logic dout;
    } serial_s;

    localparam int REG_W = 32;

    // Interrupt condition of one pin for one completed scan.
    function automatic logic pin_hit(logic edge_mode, logic pol, logic prev, logic now);
        logic h;
        if (edge_mode)
            h = pol ? (!prev && now) : (prev && !now);
        else
            h = (now == pol);
        return h;
    endfunction

endpackage

// File: rtl/spm_clkdiv.sv
module spm_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= div);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spm_scan.sv
module spm_scan
    import spm_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic [NPINS-1:0] out_img,
    input  logic             sdin,
    output serial_s          ser,
    output logic             scan_done,
    output logic [NPINS-1:0] rx_img
);
    localparam int CNT_W = $clog2(NPINS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NPINS - 1);

    phase_e           ph;
    logic [NPINS-1:0] tx_sr;
    logic [NPINS-1:0] rx_sr;
    logic [CNT_W-1:0] bit_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            tx_sr   <= '0;
            rx_sr   <= '0;
            bit_idx <= '0;
        end else if (tick) begin
            case (ph)
                PH_IDLE: if (run) ph <= PH_LOAD;
                PH_LOAD: begin
                    tx_sr   <= out_img;
                    bit_idx <= '0;
                    ph      <= PH_LOW;
                end
                PH_LOW: begin
                    rx_sr <= {sdin, rx_sr[NPINS-1:1]};
                    ph    <= PH_HIGH;
                end
                PH_HIGH: begin
                    tx_sr <= {tx_sr[NPINS-2:0], 1'b0};
                    if (bit_idx == LAST) begin
                        ph <= PH_LATCH;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        ph      <= PH_LOW;
                    end
                end
                PH_LATCH: ph <= PH_IDLE;
                default:  ph <= PH_IDLE;
            endcase
        end
    end

    assign ser.load   = (ph == PH_LOAD);
    assign ser.sclk   = (ph == PH_HIGH);
    assign ser.latch  = (ph == PH_LATCH);
    assign ser.dout   = tx_sr[NPINS-1];
    assign scan_done  = tick && (ph == PH_LATCH);
    assign rx_img     = rx_sr;
endmodule

// File: rtl/spm_irq.sv
module spm_irq
    import spm_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scan_done,
    input  logic [NPINS-1:0] rx_img,
    input  logic [NPINS-1:0] ien,
    input  logic [NPINS-1:0] mode,
    input  logic [NPINS-1:0] pol,
    input  logic [NPINS-1:0] clr_mask,
    output logic [NPINS-1:0] in_val,
    output logic [NPINS-1:0] stat,
    output logic             irq
);
    logic [NPINS-1:0] hit;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign hit[i] = pin_hit(mode[i], pol[i], in_val[i], rx_img[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_val <= '0;
            stat   <= '0;
        end else begin
            if (scan_done)
                in_val <= rx_img;
            // a new hit wins over a clear in the same cycle
            stat <= (stat & ~clr_mask) | (scan_done ? hit : '0);
        end
    end

    assign irq = |(stat & ien);
endmodule

// File: rtl/serial_pin_master.sv
module serial_pin_master
    import spm_pkg::*;
#(
    parameter  int NPINS  = 16,
    parameter  int DIV_W  = 8,
    localparam int NBANK  = (NPINS + REG_W - 1) / REG_W,
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int ADDR_W = BANK_W + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wdt_rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              ser_clk,
    output logic              ser_load,
    output logic              ser_latch,
    output logic              ser_dout,
    input  logic              ser_din,
    output logic              irq
);
    localparam int PADW = NBANK * REG_W;

    logic [NPINS-1:0] out_val, ien, mode, pol, keep;
    logic [NPINS-1:0] in_val, stat_w, rx_img_w, clr_mask;
    logic             run;
    logic [DIV_W-1:0] div;
    logic             tick_w, scan_done_w;
    serial_s          ser_w;

    regsel_e          sel;
    logic [BANK_W-1:0] bank;
    logic             bank_ok;
    logic [PADW-1:0]  mask_pad, wdata_pad;
    logic [NPINS-1:0] wmask, wbits;

    assign sel     = regsel_e'(reg_addr[2:0]);
    assign bank    = reg_addr[ADDR_W-1:3];
    assign bank_ok = (int'(bank) < NBANK);

    always_comb begin
        mask_pad  = '0;
        wdata_pad = '0;
        for (int b = 0; b < NBANK; b++) begin
            wdata_pad[b*REG_W +: REG_W] = reg_wdata;
            if (bank_ok && int'(bank) == b)
                mask_pad[b*REG_W +: REG_W] = '1;
        end
    end

    assign wmask    = (reg_we && bank_ok) ? mask_pad[NPINS-1:0] : '0;
    assign wbits    = wdata_pad[NPINS-1:0] & wmask;
    assign clr_mask = (sel == SEL_STAT) ? wbits : '0;

    function automatic logic [NPINS-1:0] merge(logic [NPINS-1:0] cur,
                                               logic [NPINS-1:0] m,
                                               logic [NPINS-1:0] d);
        return (cur & ~m) | (d & m);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            out_val <= '0;
            ien     <= '0;
            mode    <= '0;
            pol     <= '0;
            keep    <= '0;
            run     <= 1'b0;
            div     <= '0;
        end else begin
            if (wdt_rst)
                out_val <= out_val & keep;
            else if (sel == SEL_OUT)
                out_val <= merge(out_val, wmask, wbits);
            if (sel == SEL_IEN)  ien  <= merge(ien,  wmask, wbits);
            if (sel == SEL_MODE) mode <= merge(mode, wmask, wbits);
            if (sel == SEL_POL)  pol  <= merge(pol,  wmask, wbits);
            if (sel == SEL_KEEP) keep <= merge(keep, wmask, wbits);
            if (reg_we && sel == SEL_CTRL) begin
                run <= reg_wdata[0];
                div <= reg_wdata[DIV_W:1];
            end
        end
    end

    // read path
    function automatic logic [31:0] pick(logic [NPINS-1:0] v, logic [BANK_W-1:0] bk);
        logic [PADW-1:0] p;
        logic [31:0]     r;
        p = PADW'(v);
        r = '0;
        for (int b = 0; b < NBANK; b++)
            if (int'(bk) == b) r = p[b*REG_W +: REG_W];
        return r;
    endfunction

    always_comb begin
        case (sel)
            SEL_OUT:  reg_rdata = pick(out_val, bank);
            SEL_IN:   reg_rdata = pick(in_val, bank);
            SEL_IEN:  reg_rdata = pick(ien, bank);
            SEL_MODE: reg_rdata = pick(mode, bank);
            SEL_POL:  reg_rdata = pick(pol, bank);
            SEL_STAT: reg_rdata = pick(stat_w, bank);
            SEL_KEEP: reg_rdata = pick(keep, bank);
            default:  reg_rdata = 32'({div, run});
        endcase
    end

    spm_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk (clk),
        .rst (rst),
        .div (div),
        .tick(tick_w)
    );

    spm_scan #(.NPINS(NPINS)) u_scan (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_w),
        .run      (run),
        .out_img  (out_val),
        .sdin     (ser_din),
        .ser      (ser_w),
        .scan_done(scan_done_w),
        .rx_img   (rx_img_w)
    );

    spm_irq #(.NPINS(NPINS)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .scan_done(scan_done_w),
        .rx_img   (rx_img_w),
        .ien      (ien),
        .mode     (mode),
        .pol      (pol),
        .clr_mask (clr_mask),
        .in_val   (in_val),
        .stat     (stat_w),
        .irq      (irq)
    );

    assign ser_clk   = ser_w.sclk;
    assign ser_load  = ser_w.load;
    assign ser_latch = ser_w.latch;
    assign ser_dout  = ser_w.dout;
endmodule

// File: rtl/spm_master_chk.sv
module spm_master_chk #(
    parameter int NPINS = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             wdt_rst,
    input logic             sclk,
    input logic             sload,
    input logic             slatch,
    input logic             sdout,
    input logic             irq,
    input logic             scan_done,
    input logic [NPINS-1:0] out_val,
    input logic [NPINS-1:0] keep,
    input logic [NPINS-1:0] stat
);
    localparam int RC_W = $clog2(NPINS) + 2;

    logic            sclk_q;
    logic [RC_W-1:0] rise_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q   <= 1'b0;
            rise_cnt <= '0;
        end else begin
            sclk_q <= sclk;
            if (sload)
                rise_cnt <= '0;
            else if (sclk && !sclk_q)
                rise_cnt <= rise_cnt + 1'b1;
        end
    end

    assert_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sload, slatch, sclk}));

    assert_edge_count_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(slatch) |-> rise_cnt == RC_W'(NPINS));

    assert_dout_setup_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> $stable(sdout));

    assert_dout_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(sdout));

    assert_stat_on_scan_R8: assert property (@(posedge clk) disable iff (rst)
        !scan_done |=> ((stat & ~$past(stat)) == '0));

    assert_wdt_keep_R10: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |=> (out_val == ($past(out_val) & $past(keep))));

    assert_irq_needs_stat_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat != '0));
endmodule

bind serial_pin_master spm_master_chk #(.NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wdt_rst  (wdt_rst),
    .sclk     (ser_clk),
    .sload    (ser_load),
    .slatch   (ser_latch),
    .sdout    (ser_dout),
    .irq      (irq),
    .scan_done(scan_done_w),
    .out_val  (out_val),
    .keep     (keep),
    .stat     (stat_w)
);

// File: tb/tb_serial_pin_master.sv
`timescale 1ns/1ps
module tb_serial_pin_master;
    localparam int N  = 16;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wdt_rst = 1'b0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          ser_clk, ser_load, ser_latch, ser_dout, ser_din, irq;

    always #2 clk = ~clk;

    serial_pin_master #(.NPINS(N), .DIV_W(8)) dut (
        .clk(clk), .rst(rst), .wdt_rst(wdt_rst), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ser_clk(ser_clk), .ser_load(ser_load), .ser_latch(ser_latch),
        .ser_dout(ser_dout), .ser_din(ser_din), .irq(irq)
    );

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    bit done    = 0;

    // external chain model
    logic [N-1:0] pins_in = '0, pins_out = '0, in_chain = '0, out_chain = '0;
    logic sclk_p = 0, load_p = 0, latch_p = 0;
    int rises = 0, last_rises = 0, latch_cnt = 0, load_cnt = 0;
    int hi_run = 0, hi_width = 0;

    assign ser_din = in_chain[0];

    always @(negedge clk) begin
        if (ser_load) in_chain = pins_in;
        if (ser_load && !load_p) begin rises = 0; load_cnt++; end
        if (ser_clk && !sclk_p) begin
            out_chain = {out_chain[N-2:0], ser_dout};
            in_chain  = in_chain >> 1;
            rises++;
        end
        if (ser_clk) hi_run++;
        if (!ser_clk && sclk_p) begin hi_width = hi_run; hi_run = 0; end
        if (ser_latch && !latch_p) begin
            pins_out = out_chain; last_rises = rises; latch_cnt++;
        end
        sclk_p = ser_clk; load_p = ser_load; latch_p = ser_latch;
    end

    // expected state
    logic [N-1:0] e_out = '0, e_ien = '0, e_mode = '0, e_pol = '0, e_keep = '0;
    logic [N-1:0] e_stat = '0, e_prev = '0;
    int cur_div = 0;

    function automatic logic [N-1:0] hits(logic [N-1:0] p, logic [N-1:0] n,
                                          logic [N-1:0] md, logic [N-1:0] pl);
        logic [N-1:0] lvl, edg;
        lvl = ~(n ^ pl);
        edg = (pl & ~p & n) | (~pl & p & ~n);
        return (md & edg) | (~md & lvl);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d, input logic bank = 0);
        @(negedge clk);
        reg_we = 1; reg_addr = {bank, sel}; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] d, input logic bank = 0);
        @(negedge clk);
        reg_addr = {bank, sel};
        #1 d = reg_rdata;
    endtask

    task automatic do_scan(input logic [N-1:0] pins);
        int c0;
        pins_in = pins;
        c0 = latch_cnt;
        wr(3'd7, (cur_div << 1) | 1);
        while (!ser_load) @(negedge clk);
        wr(3'd7, cur_div << 1);       // R11: stop after this scan
        while (latch_cnt == c0) @(negedge clk);
        repeat (4) @(negedge clk);
        e_stat = e_stat | hits(e_prev, pins, e_mode, e_pol);
        e_prev = pins;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] d;
        chk({tag, " R3 rises"}, last_rises, N);
        chk({tag, " R4 latched image"}, 32'(pins_out), 32'(e_out));
        rd(3'd1, d); chk({tag, " R5 input value"}, d, 32'(e_prev));
        rd(3'd5, d); chk({tag, " R6/R7 status"}, d, 32'(e_stat));
        rd(3'd0, d); chk({tag, " R10 out reg"}, d, 32'(e_out));
        chk({tag, " R9 irq"}, 32'(irq), 32'(|(e_stat & e_ien)));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [N-1:0] r;
        int lc;
        void'($urandom(32'h1234_abcd));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        for (int s = 0; s < 8; s++) begin
            rd(3'(s), d);
            chk("R1 reg reset", d, 0);
        end
        chk("R1 lines idle", {ser_clk, ser_load, ser_latch, irq}, 0);

        // R12 bank beyond range and read-only input register
        wr(3'd0, 32'hFFFF, 1'b1);
        wr(3'd1, 32'hABCD);
        rd(3'd0, d); chk("R12 bad bank write", d, 0);
        rd(3'd1, d); chk("R12 input read-only", d, 0);
        rd(3'd0, d, 1'b1); chk("R12 bad bank read", d, 0);

        // directed: level high, div 2
        cur_div = 2;
        e_out = 16'hA5C3; wr(3'd0, 32'(e_out));
        e_ien = '1;  wr(3'd2, 32'(e_ien));
        e_pol = '1;  wr(3'd4, 32'(e_pol));
        do_scan(16'h8001);
        chk("R2 sclk high width div2", hi_width, 3);
        check_all("level-high");

        // R8 write 0 no effect, write 1 clears
        wr(3'd5, 0);
        rd(3'd5, d); chk("R8 write zero", d, 32'(e_stat));
        wr(3'd5, 32'h0001); e_stat[0] = 0;
        rd(3'd5, d); chk("R8 w1c", d, 32'(e_stat));

        // R7 edge rising/falling, div 0
        cur_div = 0;
        wr(3'd5, 32'hFFFF); e_stat = '0;
        e_mode = '1;    wr(3'd3, 32'(e_mode));
        e_pol = 16'h00FF; wr(3'd4, 32'(e_pol));
        do_scan(16'h0F0F);
        chk("R2 sclk high width div0", hi_width, 1);
        check_all("edge-1");
        do_scan(16'hF0F0);
        check_all("edge-2");

        // R9 disabled pins record, irq low
        e_ien = '0; wr(3'd2, 0);
        chk("R9 irq off when disabled", irq, 0);
        rd(3'd5, d); chk("R9 status kept", d, 32'(e_stat));

        // R10 watchdog
        e_keep = 16'h0FF0; wr(3'd6, 32'(e_keep));
        e_out = 16'hFFFF;  wr(3'd0, 32'(e_out));
        @(negedge clk); wdt_rst = 1; @(negedge clk); wdt_rst = 0;
        e_out = e_out & e_keep;
        rd(3'd0, d); chk("R10 wdt out", d, 32'(e_out));
        rd(3'd6, d); chk("R10 keep intact", d, 32'(e_keep));
        do_scan(16'h0000);
        check_all("wdt");

        // R11 no further scan
        lc = load_cnt;
        repeat (200) @(negedge clk);
        chk("R11 idle after stop", load_cnt, lc);

        // random
        for (int it = 0; it < 25; it++) begin
            cur_div = $urandom_range(0, 3);
            if ($urandom_range(0, 1)) begin e_out  = N'($urandom); wr(3'd0, 32'(e_out)); end
            if ($urandom_range(0, 1)) begin e_ien  = N'($urandom); wr(3'd2, 32'(e_ien)); end
            if ($urandom_range(0, 2) == 0) begin e_mode = N'($urandom); wr(3'd3, 32'(e_mode)); end
            if ($urandom_range(0, 2) == 0) begin e_pol  = N'($urandom); wr(3'd4, 32'(e_pol)); end
            if ($urandom_range(0, 1)) begin
                r = N'($urandom); wr(3'd5, 32'(r)); e_stat = e_stat & ~r;
            end
            if ($urandom_range(0, 4) == 0) begin
                e_keep = N'($urandom); wr(3'd6, 32'(e_keep));
                @(negedge clk); wdt_rst = 1; @(negedge clk); wdt_rst = 0;
                e_out = e_out & e_keep;
            end
            do_scan(N'($urandom));
            check_all("random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule